// File: doc/BRIEF.md
# Unary Register Dependency Matrix

This block is the hazard-tracking core of an extended scoreboard for an out-of-order issue engine. It tracks a set of function units against a set of architectural registers. For each unit it keeps two rows of single-bit set/reset cells. The first row marks the one register the unit will write. The second row marks the source registers the unit still has to read. Because both rows are one-hot, or few-hot, unary vectors, a hazard check on a register is one AND of two bits. No register number is compared anywhere.

Issue logic presents one request per unit, together with that unit's destination row, source row and shadow mask. Any number of units may be accepted in the same cycle. For each unit the block grants a go-read pulse when the unit may capture its operands. It grants a go-write pulse when the held result may be written to the register file. A unit that is still speculative is shadowed: its result stays in the unit's own latches until every shadow bit on it has been cleared. When a shadow resolves as failed, every unit carrying that bit is cancelled and released without writing.

Top module: `sbm_dep_matrix`

## Requirements
- R1: After a synchronous reset every unit is free (`fu_busy` all zero), and no go-read, go-write or cancel is raised while the inputs are idle.
- R2: A request on unit u is accepted (`issue_ack[u]`=1) only if the unit is free and its destination row shares no bit with the destination row of any busy unit, or with that of any lower-indexed unit requesting in the same cycle. Otherwise `issue_stall[u]`=1. Bit u*NUM_REG+r of `issue_dst` and `issue_src` stands for register r of unit u.
- R3: Several units with disjoint destinations are accepted in the same cycle.
- R4: Unit v counts as older than u if v was busy when u was accepted, or v was accepted in the same cycle with a lower index. A busy unit gets exactly one `go_read` pulse. It fires when no older, still busy unit has a destination bit on any of its pending source bits. The unit must not be cancelled in that cycle.
- R5: `go_write[u]` needs all of the following: an earlier go-read, a `fu_done[u]` pulse seen since issue, no shadow bit set, and no write-after-read hazard.
- R6: A unit may not write a register while any older unit still has that register pending as a source, that is, before that unit's go-read.
- R7: Bit s of `issue_shadow` (slot u*NUM_SHADOW+s) shadows unit u on condition s and holds back its write. A `shadow_ok[s]` pulse clears bit s on every unit.
- R8: A `shadow_fail[s]` pulse raises `fu_cancel` in that cycle on every busy unit that carries bit s. Such a unit gets no go-write.
- R9: After a go-write or a cancel, the unit is free in the next cycle, its rows no longer cause hazards, and it can be reissued.
- R10: `go_read` and `go_write` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_req | input | NUM_FU | Issue request per unit |
| issue_dst | input | NUM_FU*NUM_REG | Destination row per unit (one-hot or zero) |
| issue_src | input | NUM_FU*NUM_REG | Source rows per unit |
| issue_shadow | input | NUM_FU*NUM_SHADOW | Shadow conditions per unit at issue |
| fu_done | input | NUM_FU | Pipeline result ready in unit latch |
| shadow_ok | input | NUM_SHADOW | Shadow condition resolved as good |
| shadow_fail | input | NUM_SHADOW | Shadow condition resolved as failed |
| issue_ack | output | NUM_FU | Request accepted |
| issue_stall | output | NUM_FU | Request refused |
| go_read | output | NUM_FU | Operand capture grant |
| go_write | output | NUM_FU | Register write grant |
| fu_cancel | output | NUM_FU | Unit cancelled, result dropped |
| fu_busy | output | NUM_FU | Unit in flight |

## Verification
The hardest situation to reach is a chain of three units. A young writer has finished and is free of shadows, yet it must wait because an older reader of its destination is itself stuck on a read-after-write hazard. That hazard comes from a still older writer that is shadowed. A directed sequence builds exactly this chain. It then releases the shadow and checks the order of the three grants that follow, cycle by cycle. Random stimulus on a small configuration then mixes issue, completion and shadow resolution. Each cycle it is compared against a bench model of the requirements.

// File: rtl/sbm_pkg.sv
// Package: shared defaults and the per-unit status record of the
// dependency matrix. Assumes nothing beyond IEEE 1800-2017.
package sbm_pkg;
    localparam int unsigned SBM_FU_DEF  = 10;
    localparam int unsigned SBM_REG_DEF = 32;
    localparam int unsigned SBM_SHD_DEF = 4;

    // Lifecycle flags of one function unit
    typedef struct packed {
        logic busy;   // instruction in flight
        logic rdone;  // operands captured (go-read seen)
        logic done;   // result held in unit latch
    } unit_flags_t;
endpackage

// File: rtl/sbm_cell.sv
// Module: one matrix cell, an independent set/reset bit.
// Clear wins over set; the owner never raises both for a useful reason.
module sbm_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Hold, set or clear the single dependency bit
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (clr_i) q <= 1'b0;
        else if (set_i) q <= 1'b1;
    end

    a_r9_cell_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q);
endmodule

// File: rtl/sbm_row.sv
// Module: the two unary rows of one unit, a destination row and a row of
// pending sources. Assumes load and release never coincide (load needs a
// free unit, release needs a busy one).
module sbm_row #(
    parameter int unsigned NUM_REG = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [NUM_REG-1:0] dst_i,
    input  logic [NUM_REG-1:0] src_i,
    input  logic               read_grant_i,
    input  logic               release_i,
    output logic [NUM_REG-1:0] dst_q,
    output logic [NUM_REG-1:0] srcp_q
);
    for (genvar r = 0; r < NUM_REG; r++) begin : g_cell
        sbm_cell i_dst (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(load_i & dst_i[r]),
            .clr_i(release_i),
            .q    (dst_q[r])
        );
        sbm_cell i_src (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(load_i & src_i[r]),
            .clr_i(release_i | read_grant_i),
            .q    (srcp_q[r])
        );
    end

    a_r4_sources_cleared_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        read_grant_i && !load_i |=> srcp_q == '0);
endmodule

// File: rtl/sbm_unit.sv
// Module: lifecycle state of one function unit: busy/read/done flags,
// its shadow bits and the vector of units older than it.
// Assumes freed_i carries this cycle's release of every unit.
module sbm_unit #(
    parameter int unsigned NUM_FU     = 10,
    parameter int unsigned NUM_SHADOW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [NUM_SHADOW-1:0] shadow_i,
    input  logic [NUM_FU-1:0]     older_i,
    input  logic                  fu_done_i,
    input  logic                  read_grant_i,
    input  logic                  release_i,
    input  logic [NUM_FU-1:0]     freed_i,
    input  logic [NUM_SHADOW-1:0] shadow_ok_i,
    output sbm_pkg::unit_flags_t  flags_o,
    output logic [NUM_SHADOW-1:0] shadow_o,
    output logic [NUM_FU-1:0]     older_o
);
    // Track busy, operand-captured and result-ready flags
    always_ff @(posedge clk) begin
        if (!rst_n || release_i) begin
            flags_o <= '0;
        end else if (load_i) begin
            flags_o <= '{busy: 1'b1, rdone: 1'b0, done: 1'b0};
        end else if (flags_o.busy) begin
            if (read_grant_i) flags_o.rdone <= 1'b1;
            if (fu_done_i)    flags_o.done  <= 1'b1;
        end
    end

    // Shadow bits: loaded at issue, cleared one by one as conditions resolve
    always_ff @(posedge clk) begin
        if (!rst_n || release_i) shadow_o <= '0;
        else if (load_i)         shadow_o <= shadow_i;
        else                     shadow_o <= shadow_o & ~shadow_ok_i;
    end

    // Age vector: units in flight ahead of this one, dropped as they leave
    always_ff @(posedge clk) begin
        if (!rst_n || release_i) older_o <= '0;
        else if (load_i)         older_o <= older_i & ~freed_i;
        else                     older_o <= older_o & ~freed_i;
    end

    a_r7_shadow_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o.busy && !load_i |=> (shadow_o & ~$past(shadow_o)) == '0);
    a_r4_older_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o.busy && !load_i |=> (older_o & ~$past(older_o)) == '0);
endmodule

// File: rtl/sbm_dep_matrix.sv
// Module: unit-by-register dependency matrix with issue acceptance,
// go-read/go-write grants and shadow cancellation. Hazards are found by
// ANDing unary rows; no register numbers are compared. Assumes the issue
// side sends a one-hot (or zero) destination row per request.
module sbm_dep_matrix #(
    parameter int unsigned NUM_FU     = sbm_pkg::SBM_FU_DEF,
    parameter int unsigned NUM_REG    = sbm_pkg::SBM_REG_DEF,
    parameter int unsigned NUM_SHADOW = sbm_pkg::SBM_SHD_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_FU-1:0]            issue_req,
    input  logic [NUM_FU*NUM_REG-1:0]    issue_dst,
    input  logic [NUM_FU*NUM_REG-1:0]    issue_src,
    input  logic [NUM_FU*NUM_SHADOW-1:0] issue_shadow,
    input  logic [NUM_FU-1:0]            fu_done,
    input  logic [NUM_SHADOW-1:0]        shadow_ok,
    input  logic [NUM_SHADOW-1:0]        shadow_fail,
    output logic [NUM_FU-1:0]            issue_ack,
    output logic [NUM_FU-1:0]            issue_stall,
    output logic [NUM_FU-1:0]            go_read,
    output logic [NUM_FU-1:0]            go_write,
    output logic [NUM_FU-1:0]            fu_cancel,
    output logic [NUM_FU-1:0]            fu_busy
);
    import sbm_pkg::*;

    logic [NUM_REG-1:0]    in_dst   [NUM_FU];
    logic [NUM_REG-1:0]    in_src   [NUM_FU];
    logic [NUM_SHADOW-1:0] in_shd   [NUM_FU];
    logic [NUM_REG-1:0]    dst_q    [NUM_FU];
    logic [NUM_REG-1:0]    srcp_q   [NUM_FU];
    logic [NUM_SHADOW-1:0] shd_q    [NUM_FU];
    logic [NUM_FU-1:0]     old_q    [NUM_FU];
    logic [NUM_FU-1:0]     old_init [NUM_FU];
    logic [NUM_REG-1:0]    wr_block [NUM_FU];
    logic [NUM_REG-1:0]    old_wr   [NUM_FU];
    logic [NUM_REG-1:0]    old_rd   [NUM_FU];
    unit_flags_t           flags    [NUM_FU];
    logic [NUM_FU-1:0]     release_v;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        assign in_dst[u] = issue_dst[u*NUM_REG +: NUM_REG];
        assign in_src[u] = issue_src[u*NUM_REG +: NUM_REG];
        assign in_shd[u] = issue_shadow[u*NUM_SHADOW +: NUM_SHADOW];
        assign fu_busy[u] = flags[u].busy;

        sbm_row #(.NUM_REG(NUM_REG)) i_row (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (issue_ack[u]),
            .dst_i       (in_dst[u]),
            .src_i       (in_src[u]),
            .read_grant_i(go_read[u]),
            .release_i   (release_v[u]),
            .dst_q       (dst_q[u]),
            .srcp_q      (srcp_q[u])
        );

        sbm_unit #(.NUM_FU(NUM_FU), .NUM_SHADOW(NUM_SHADOW)) i_unit (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (issue_ack[u]),
            .shadow_i    (in_shd[u]),
            .older_i     (old_init[u]),
            .fu_done_i   (fu_done[u]),
            .read_grant_i(go_read[u]),
            .release_i   (release_v[u]),
            .freed_i     (release_v),
            .shadow_ok_i (shadow_ok),
            .flags_o     (flags[u]),
            .shadow_o    (shd_q[u]),
            .older_o     (old_q[u])
        );
    end

    // Destinations a new request must avoid: busy units and lower requesters
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            wr_block[u] = '0;
            for (int v = 0; v < NUM_FU; v++) begin
                if (v != u) wr_block[u] = wr_block[u] | dst_q[v];
                if (v < u && issue_req[v]) wr_block[u] = wr_block[u] | in_dst[v];
            end
        end
    end

    // Accept or stall each request
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            issue_ack[u]   = issue_req[u] && !flags[u].busy
                             && ((in_dst[u] & wr_block[u]) == '0);
            issue_stall[u] = issue_req[u] && !issue_ack[u];
        end
    end

    // Age vector for new issues: all busy units plus lower same-cycle issues
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            old_init[u] = fu_busy;
            for (int v = 0; v < u; v++)
                if (issue_ack[v]) old_init[u][v] = 1'b1;
        end
    end

    // Collect pending writes and reads of each unit's older units
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            old_wr[u] = '0;
            old_rd[u] = '0;
            for (int v = 0; v < NUM_FU; v++) begin
                if (old_q[u][v]) begin
                    old_wr[u] = old_wr[u] | dst_q[v];
                    old_rd[u] = old_rd[u] | srcp_q[v];
                end
            end
        end
    end

    // Grants, cancellation and release per unit
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            fu_cancel[u] = flags[u].busy && ((shd_q[u] & shadow_fail) != '0);
            go_read[u]   = flags[u].busy && !flags[u].rdone && !fu_cancel[u]
                           && ((srcp_q[u] & old_wr[u]) == '0);
            go_write[u]  = flags[u].busy && flags[u].rdone && flags[u].done
                           && (shd_q[u] == '0)
                           && ((dst_q[u] & old_rd[u]) == '0);
            release_v[u] = go_write[u] || fu_cancel[u];
        end
    end

    a_r1_reset_frees_all: assert property (@(posedge clk)
        !rst_n |=> fu_busy == '0);

    for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
        a_r9_ack_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
            issue_ack[u] |=> fu_busy[u]);
        a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            go_read[u] |=> !go_read[u]);
        a_r10_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            go_write[u] |=> !go_write[u]);
        a_r8_cancel_frees: assert property (@(posedge clk) disable iff (!rst_n)
            fu_cancel[u] |=> !fu_busy[u]);
        a_r8_no_write_when_cancelled: assert property (@(posedge clk) disable iff (!rst_n)
            fu_cancel[u] |-> !go_write[u]);
        a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
            go_write[u] |-> !go_read[u] && !issue_ack[u]);
        for (genvar v = u + 1; v < NUM_FU; v++) begin : g_pair
            a_r2_unique_dest: assert property (@(posedge clk) disable iff (!rst_n)
                (dst_q[u] & dst_q[v]) == '0);
        end
    end
endmodule

// File: tb/test_sbm_dep_matrix.sv
module test_sbm_dep_matrix;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 4;
    localparam int NR = 8;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NF-1:0] req, done_in;
    logic [NR-1:0] in_dst [NF];
    logic [NR-1:0] in_src [NF];
    logic [NS-1:0] in_sh  [NF];
    logic [NS-1:0] ok_in, fail_in;
    logic [NF*NR-1:0] f_dst, f_src;
    logic [NF*NS-1:0] f_sh;
    logic [NF-1:0] ack, stall, gr, gw, cancel, busy;

    always_comb begin
        for (int u = 0; u < NF; u++) begin
            f_dst[u*NR +: NR] = in_dst[u];
            f_src[u*NR +: NR] = in_src[u];
            f_sh[u*NS +: NS]  = in_sh[u];
        end
    end

    sbm_dep_matrix #(.NUM_FU(NF), .NUM_REG(NR), .NUM_SHADOW(NS)) i_sbm_dep_matrix (
        .clk(clk), .rst_n(rst_n), .issue_req(req), .issue_dst(f_dst),
        .issue_src(f_src), .issue_shadow(f_sh), .fu_done(done_in),
        .shadow_ok(ok_in), .shadow_fail(fail_in), .issue_ack(ack),
        .issue_stall(stall), .go_read(gr), .go_write(gw),
        .fu_cancel(cancel), .fu_busy(busy));

    // Bench model of the requirements
    bit [NR-1:0] m_dst [NF];
    bit [NR-1:0] m_src [NF];
    bit [NS-1:0] m_sh  [NF];
    bit [NF-1:0] m_old [NF];
    bit [NF-1:0] m_busy, m_rd, m_done;
    bit [NF-1:0] e_ack, e_gr, e_gw, e_cn;
    bit [NF-1:0] o_ack, o_gr, o_gw, o_cn, o_busy, p_gr, p_gw;
    int checks = 0;
    int errors = 0;

    task automatic chk(string tag, logic [NF-1:0] act, logic [NF-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int u = 0; u < NF; u++) begin
            m_dst[u] = '0; m_src[u] = '0; m_sh[u] = '0; m_old[u] = '0;
        end
        m_busy = '0; m_rd = '0; m_done = '0; p_gr = '0; p_gw = '0;
    endtask

    task automatic model_eval();
        for (int u = 0; u < NF; u++) begin
            bit [NR-1:0] blk, owr, ord;
            blk = '0; owr = '0; ord = '0;
            for (int v = 0; v < NF; v++) begin
                if (v != u) blk |= m_dst[v];
                if (v < u && req[v]) blk |= in_dst[v];
                if (m_old[u][v]) begin owr |= m_dst[v]; ord |= m_src[v]; end
            end
            e_ack[u] = req[u] && !m_busy[u] && ((in_dst[u] & blk) == '0);
            e_cn[u]  = m_busy[u] && ((m_sh[u] & fail_in) != '0);
            e_gr[u]  = m_busy[u] && !m_rd[u] && !e_cn[u] && ((m_src[u] & owr) == '0);
            e_gw[u]  = m_busy[u] && m_rd[u] && m_done[u] && (m_sh[u] == '0)
                       && ((m_dst[u] & ord) == '0);
        end
    endtask

    task automatic model_update();
        bit [NF-1:0] rel, ob;
        rel = e_gw | e_cn;
        ob = m_busy;
        for (int u = 0; u < NF; u++) begin
            if (rel[u]) begin
                m_busy[u] = 0; m_rd[u] = 0; m_done[u] = 0;
                m_dst[u] = '0; m_src[u] = '0; m_sh[u] = '0; m_old[u] = '0;
            end else if (e_ack[u]) begin
                bit [NF-1:0] oi;
                oi = ob;
                for (int v = 0; v < u; v++) if (e_ack[v]) oi[v] = 1;
                m_busy[u] = 1; m_rd[u] = 0; m_done[u] = 0;
                m_dst[u] = in_dst[u]; m_src[u] = in_src[u]; m_sh[u] = in_sh[u];
                m_old[u] = oi & ~rel;
            end else if (m_busy[u]) begin
                if (e_gr[u]) begin m_rd[u] = 1; m_src[u] = '0; end
                if (done_in[u]) m_done[u] = 1;
                m_sh[u] &= ~ok_in;
                m_old[u] &= ~rel;
            end
        end
    endtask

    // One cycle: inputs already driven at the falling edge
    task automatic cycle();
        #1;
        model_eval();
        o_ack = ack; o_gr = gr; o_gw = gw; o_cn = cancel; o_busy = busy;
        chk("R2 issue_ack", ack, e_ack);
        chk("R2 issue_stall", stall, req & ~e_ack);
        chk("R4 go_read", gr, e_gr);
        chk("R5 go_write", gw, e_gw);
        chk("R8 fu_cancel", cancel, e_cn);
        chk("R9 fu_busy", busy, m_busy);
        chk("R10 go_read single pulse", gr & p_gr, '0);
        chk("R10 go_write single pulse", gw & p_gw, '0);
        p_gr = gr; p_gw = gw;
        model_update();
        @(negedge clk);
    endtask

    task automatic idle_in();
        req = '0; done_in = '0; ok_in = '0; fail_in = '0;
        for (int u = 0; u < NF; u++) begin
            in_dst[u] = '0; in_src[u] = '0; in_sh[u] = '0;
        end
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 1'b0;
        model_clear();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk("R1 reset busy", busy, '0);
        chk("R1 reset grants", gr | gw | cancel, '0);
        @(negedge clk);

        // R2: same destination in one cycle, lower index wins
        req = 4'b0011; in_dst[0] = 8'h08; in_dst[1] = 8'h08;
        cycle();
        chk("R2 lower index accepted", o_ack, 4'b0001);
        idle_in();
        req = 4'b0010; in_dst[1] = 8'h08;
        cycle();
        chk("R2 pending write stalls", o_ack, 4'b0000);
        // R3: two disjoint issues together
        idle_in();
        req = 4'b1100; in_dst[2] = 8'h10; in_dst[3] = 8'h20;
        cycle();
        chk("R3 dual issue", o_ack, 4'b1100);
        idle_in();

        // R6/R7 chain: shadowed writer, blocked reader, young writer
        do_reset();
        req = 4'b1000; in_dst[3] = 8'h40; in_sh[3] = 2'b01;
        cycle(); idle_in();
        req = 4'b0001; in_src[0] = 8'h60;
        cycle(); idle_in();
        req = 4'b0010; in_dst[1] = 8'h20;
        cycle(); idle_in();
        done_in = 4'b1010;
        cycle(); idle_in();
        cycle();
        chk("R6 write held by older reader", o_gw & 4'b0010, 4'b0000);
        chk("R7 write held by shadow", o_gw & 4'b1000, 4'b0000);
        ok_in = 2'b01;
        cycle(); idle_in();
        cycle();
        chk("R7 write after shadow clears", o_gw, 4'b1000);
        cycle();
        chk("R4 read after older write", o_gr, 4'b0001);
        cycle();
        chk("R6 write after reader captured", o_gw, 4'b0010);

        // R8/R9: failed shadow cancels, unit reusable
        do_reset();
        req = 4'b0100; in_dst[2] = 8'h04; in_sh[2] = 2'b10;
        cycle(); idle_in();
        fail_in = 2'b10;
        cycle(); idle_in();
        chk("R8 cancel raised", o_cn, 4'b0100);
        req = 4'b0100; in_dst[2] = 8'h04;
        cycle(); idle_in();
        chk("R9 reissue after cancel", o_ack, 4'b0100);

        // Random traffic against the model
        do_reset();
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            idle_in();
            for (int u = 0; u < NF; u++) begin
                req[u] = ($urandom % 100) < 30;
                in_dst[u] = (($urandom % 4) != 0) ? NR'(1 << ($urandom % NR)) : '0;
                in_src[u] = NR'($urandom & $urandom & $urandom);
                in_sh[u]  = (($urandom % 4) == 0) ? NS'($urandom) : '0;
                done_in[u] = ($urandom % 100) < 30;
            end
            for (int s = 0; s < NS; s++) begin
                ok_in[s]   = ($urandom % 100) < 10;
                fail_in[s] = ($urandom % 100) < 4;
            end
            cycle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule